// File: doc/BRIEF.md
# Banked Exception-Entry Controller

This block holds the mode-dependent architectural state of a small 32-bit core: the live stack register (r29), link register (r30), saved-status register, status word and program counter (r31). Each privileged mode also has a shadow bank with its own copy of r29, r30 and the saved-status register. A mode change moves the outgoing values into the outgoing mode's bank and loads the live registers from the incoming mode's bank.

An exception request carries a kind code. In one clock edge the block picks the target mode for that kind, copies the pre-entry status word into the new mode's saved-status register, and writes the target mode into the status word's mode field with the interrupt-disable bit set. It also moves the program counter into the link register and loads the program counter with a vector address. A control input selects a low or a high vector base. A plain write port lets the surrounding core update the live registers. An unknown exception kind or an unmapped requested mode sets a sticky error flag and changes nothing else.

Top module: `xbk_ctrl`

## Requirements
- R1: Mode codes are 5 bits in status bits [4:0]. There are four banks: user 0x10 and system 0x1F share bank 0, privileged 0x13 uses bank 1, trap 0x17 uses bank 2 and interrupt 0x12 uses bank 3. After reset the status word is 0x93 (privileged mode with the interrupt-disable bit, bit 7, set). All other registers and banks are zero, and the error flag and entry pulse are low.
- R2: On a mode change between modes with different banks, the live r29, r30 and saved-status values are stored into the outgoing bank, and the incoming bank's values become live, all on the same edge.
- R3: When the requested or target mode maps to the current bank (the same mode, or user/system), no bank swap happens. On a plain mode request, r29, r30 and saved-status stay as they are and only the mode field changes.
- R4: Exception kind 0 (software) enters privileged mode, kind 1 (instruction-fetch trap) and kind 2 (data trap) enter trap mode, and kind 3 (interrupt) enters interrupt mode.
- R5: On exception entry the saved-status register receives the status word as it was before entry. The status word keeps its other bits, takes the target mode in [4:0], and has bit 7 set.
- R6: On exception entry r30 receives the pre-entry program counter. The program counter receives base + offset, where base is 0x0000_0000 when the vector-select input is 0 and 0xFFFF_0000 when it is 1. The offsets are 0x08 for kind 0, 0x0C for kind 1, 0x10 for kind 2 and 0x18 for kind 3.
- R7: The entry-done output is high for exactly the one cycle after the edge that accepted a valid exception request.
- R8: Exception kinds 4 to 7, or a mode request for a code not listed in R1, set the error flag. The flag stays set until reset, and no architectural register changes.
- R9: An exception request takes precedence over a mode request in the same cycle, and a mode request takes precedence over a register write. The losing request has no effect.
- R10: A register write selects r29 (0), r30 (1), program counter (2), saved-status (3) or status (4). A status write replaces bits [31:5] and leaves the mode field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_vld_i | input | 1 | Exception request strobe |
| exc_kind_i | input | 3 | Exception kind code |
| vec_hi_i | input | 1 | Selects the high vector base |
| mode_vld_i | input | 1 | Mode change request strobe |
| mode_req_i | input | 5 | Requested mode code |
| wr_en_i | input | 1 | Live register write strobe |
| wr_sel_i | input | 3 | Live register write select |
| wr_data_i | input | 32 | Live register write data |
| sp_o | output | 32 | Live r29 |
| lr_o | output | 32 | Live r30 |
| pc_o | output | 32 | Program counter r31 |
| status_o | output | 32 | Status word |
| sstat_o | output | 32 | Live saved-status register |
| exc_done_o | output | 1 | One-cycle exception-entry pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest state to reach is a bank that holds values the bench planted long before, and that must come back intact after several entries and mode changes in between. The bench builds this state through the write port. It plants distinct values in the privileged and user banks, then chains a software exception, a fetch trap, a same-mode data trap and an interrupt. Finally it walks back through the trap and privileged modes and expects each bank's planted or captured contents to reappear.

// File: rtl/xbk_pkg.sv
// Package: shared widths, mode codes, kind codes and bank record type.
// Assumes a 32-bit data path and a 5-bit mode field at the bottom of status.
package xbk_pkg;
    localparam int DW      = 32;
    localparam int MW      = 5;
    localparam int NBANK   = 4;
    localparam int BIW     = $clog2(NBANK);
    localparam int KW      = 3;
    localparam int IBIT    = 7;

    localparam logic [MW-1:0] M_USER = 5'h10;
    localparam logic [MW-1:0] M_INTR = 5'h12;
    localparam logic [MW-1:0] M_PRIV = 5'h13;
    localparam logic [MW-1:0] M_TRAP = 5'h17;
    localparam logic [MW-1:0] M_SYS  = 5'h1F;

    localparam logic [DW-1:0] STAT_RST = 32'h0000_0093;

    typedef enum logic [KW-1:0] {
        K_SOFT  = 3'd0,
        K_IFTCH = 3'd1,
        K_DATA  = 3'd2,
        K_IRQ   = 3'd3
    } kind_e;

    typedef struct packed {
        logic [DW-1:0] sp;
        logic [DW-1:0] lr;
        logic [DW-1:0] ss;
    } bank_t;
endpackage

// File: rtl/xbk_mode_map.sv
// Mode map: turns a mode code into a bank index.
// Assumes user and system modes share bank 0; any other code is unmapped.
module xbk_mode_map
    import xbk_pkg::*;
(
    input  logic [MW-1:0]  mode_i,
    output logic [BIW-1:0] idx_o,
    output logic           ok_o
);
    // Decode mode code to bank index and a valid flag.
    always_comb begin
        ok_o  = 1'b1;
        idx_o = '0;
        unique case (mode_i)
            M_USER, M_SYS: idx_o = BIW'(0);
            M_PRIV:        idx_o = BIW'(1);
            M_TRAP:        idx_o = BIW'(2);
            M_INTR:        idx_o = BIW'(3);
            default:       ok_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/xbk_kind_dec.sv
// Kind decoder: gives the target mode and vector offset for an exception kind.
// Assumes offsets are byte offsets that fit below the 64 KiB vector page.
module xbk_kind_dec
    import xbk_pkg::*;
(
    input  logic [KW-1:0] kind_i,
    output logic [MW-1:0] tgt_o,
    output logic [7:0]    off_o,
    output logic          ok_o
);
    // Map each known kind to its mode and offset; flag others as invalid.
    always_comb begin
        ok_o  = 1'b1;
        tgt_o = M_PRIV;
        off_o = 8'h00;
        case (kind_i)
            K_SOFT:  begin tgt_o = M_PRIV; off_o = 8'h08; end
            K_IFTCH: begin tgt_o = M_TRAP; off_o = 8'h0C; end
            K_DATA:  begin tgt_o = M_TRAP; off_o = 8'h10; end
            K_IRQ:   begin tgt_o = M_INTR; off_o = 8'h18; end
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xbk_bank_file.sv
// Bank file: one shadow record per bank, written on swap, read combinationally.
// Assumes the caller never writes and reads the same bank on one edge.
module xbk_bank_file
    import xbk_pkg::*;
#(
    parameter int NB = NBANK,
    localparam int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  bank_t         wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output bank_t         rd_data_o
);
    bank_t store_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        // Hold one bank record; load it when this bank is the outgoing one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store_q[g] <= '0;
            else if (wr_en_i && wr_idx_i == IW'(g))
                store_q[g] <= wr_data_i;
        end
    end

    // Present the incoming bank's record.
    always_comb rd_data_o = store_q[rd_idx_i];

    AST_SWAP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> wr_idx_i != rd_idx_i); // R3
endmodule

// File: rtl/xbk_ctrl.sv
// Exception-entry controller: owns live r29/r30/r31, status and saved-status,
// swaps banks on mode change and performs single-edge exception entry.
// Assumes the mode field only changes through mode requests or entries.
module xbk_ctrl
    import xbk_pkg::*;
#(
    parameter logic [DW-1:0] VEC_LO = 32'h0000_0000,
    parameter logic [DW-1:0] VEC_HI = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_vld_i,
    input  logic [KW-1:0] exc_kind_i,
    input  logic          vec_hi_i,
    input  logic          mode_vld_i,
    input  logic [MW-1:0] mode_req_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] lr_o,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] sstat_o,
    output logic          exc_done_o,
    output logic          err_o
);
    logic [DW-1:0]  sp_q, lr_q, pc_q, st_q, ss_q;
    logic           done_q, err_q;
    logic [BIW-1:0] cur_idx, req_idx, tgt_idx, new_idx;
    logic           cur_ok, req_ok, tgt_ok, kind_ok;
    logic [MW-1:0]  tgt_mode;
    logic [7:0]     vec_off;
    logic           do_exc, exc_bad, do_mode, mode_bad, do_wr, swap;
    bank_t          bank_out, bank_in;

    xbk_mode_map u_map_cur (.mode_i(st_q[MW-1:0]), .idx_o(cur_idx), .ok_o(cur_ok));
    xbk_mode_map u_map_req (.mode_i(mode_req_i),   .idx_o(req_idx), .ok_o(req_ok));
    xbk_mode_map u_map_tgt (.mode_i(tgt_mode),     .idx_o(tgt_idx), .ok_o(tgt_ok));
    xbk_kind_dec u_kind (.kind_i(exc_kind_i), .tgt_o(tgt_mode), .off_o(vec_off), .ok_o(kind_ok));

    // Arbitrate requests: exception, then mode change, then register write.
    always_comb begin
        do_exc   = exc_vld_i && kind_ok;
        exc_bad  = exc_vld_i && !kind_ok;
        do_mode  = !exc_vld_i && mode_vld_i && req_ok;
        mode_bad = !exc_vld_i && mode_vld_i && !req_ok;
        do_wr    = !exc_vld_i && !mode_vld_i && wr_en_i;
        new_idx  = do_exc ? tgt_idx : req_idx;
        swap     = (do_exc || do_mode) && (new_idx != cur_idx);
        bank_out = '{sp: sp_q, lr: lr_q, ss: ss_q};
    end

    xbk_bank_file #(.NB(NBANK)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(swap), .wr_idx_i(cur_idx), .wr_data_i(bank_out),
        .rd_idx_i(new_idx), .rd_data_o(bank_in)
    );

    // Update live registers according to the winning request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0; lr_q <= '0; pc_q <= '0; ss_q <= '0;
            st_q <= STAT_RST; done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            done_q <= do_exc;
            if (exc_bad || mode_bad) err_q <= 1'b1;
            if (do_exc) begin
                if (swap) sp_q <= bank_in.sp;
                lr_q <= pc_q;
                ss_q <= st_q;
                st_q <= {st_q[DW-1:IBIT+1], 1'b1, st_q[IBIT-1:MW], tgt_mode};
                pc_q <= (vec_hi_i ? VEC_HI : VEC_LO) | DW'(vec_off);
            end else if (do_mode) begin
                if (swap) begin
                    sp_q <= bank_in.sp;
                    lr_q <= bank_in.lr;
                    ss_q <= bank_in.ss;
                end
                st_q[MW-1:0] <= mode_req_i;
            end else if (do_wr) begin
                case (wr_sel_i)
                    3'd0: sp_q <= wr_data_i;
                    3'd1: lr_q <= wr_data_i;
                    3'd2: pc_q <= wr_data_i;
                    3'd3: ss_q <= wr_data_i;
                    3'd4: st_q <= {wr_data_i[DW-1:MW], st_q[MW-1:0]};
                    default: ;
                endcase
            end
        end
    end

    assign sp_o = sp_q;  assign lr_o = lr_q;  assign pc_o = pc_q;
    assign status_o = st_q;  assign sstat_o = ss_q;
    assign exc_done_o = done_q;  assign err_o = err_q;

    AST_CUR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ok && tgt_ok); // R1
    AST_DONE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_done_o |-> $past(exc_vld_i)); // R7
    AST_ENTRY_IDIS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_done_o |-> status_o[IBIT]); // R5
    AST_ENTRY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_done_o |-> lr_o == $past(pc_o)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R8
    AST_BAD_KIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_bad |=> $stable(pc_o) && $stable(status_o) && $stable(lr_o)); // R8
    AST_SAME_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mode && req_idx == cur_idx) |=> $stable(sp_o) && $stable(lr_o) && $stable(sstat_o)); // R3
endmodule

// File: tb/xbk_ctrl_bench.sv
module xbk_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_vld, vec_hi, mode_vld, wr_en;
    logic [2:0]  exc_kind, wr_sel;
    logic [4:0]  mode_req;
    logic [31:0] wr_data;
    logic [31:0] sp, lr, pc, st, ss;
    logic        done, err;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbk_ctrl u_xbk_ctrl (
        .clk(clk), .rst_n(rst_n),
        .exc_vld_i(exc_vld), .exc_kind_i(exc_kind), .vec_hi_i(vec_hi),
        .mode_vld_i(mode_vld), .mode_req_i(mode_req),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .sp_o(sp), .lr_o(lr), .pc_o(pc), .status_o(st), .sstat_o(ss),
        .exc_done_o(done), .err_o(err)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(string req, logic [31:0] esp, logic [31:0] elr,
                            logic [31:0] epc, logic [31:0] est, logic [31:0] ess);
        chk(req, "r29", sp, esp);
        chk(req, "r30", lr, elr);
        chk(req, "pc", pc, epc);
        chk(req, "status", st, est);
        chk(req, "sstat", ss, ess);
    endtask

    task automatic idle();
        exc_vld = 0; exc_kind = 0; vec_hi = 0; mode_vld = 0; mode_req = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk); idle(); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); idle();
    endtask

    task automatic mode(logic [4:0] m);
        @(negedge clk); idle(); mode_vld = 1; mode_req = m;
        @(negedge clk); idle();
    endtask

    task automatic exc(logic [2:0] k, logic hi);
        @(negedge clk); idle(); exc_vld = 1; exc_kind = k; vec_hi = hi;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk_regs("R1", 0, 0, 0, 32'h93, 0);
        chk("R1", "err", {31'b0, err}, 0);
        chk("R1", "done", {31'b0, done}, 0);
    endtask

    task automatic t_bad_mode();
        wr(3'd0, 32'hAAAA);
        mode(5'h0A);
        chk("R8", "err after bad mode", {31'b0, err}, 1);
        chk_regs("R8", 32'hAAAA, 0, 0, 32'h93, 0);
        @(negedge clk);
        chk("R8", "err held", {31'b0, err}, 1);
    endtask

    task automatic t_swap();
        wr(3'd0, 32'h1111); wr(3'd1, 32'h2222); wr(3'd3, 32'h3333);
        mode(5'h10);
        chk_regs("R2", 0, 0, 0, 32'h90, 0);
        wr(3'd0, 32'h4444); wr(3'd1, 32'h5555); wr(3'd3, 32'h6666);
        mode(5'h13);
        chk_regs("R2", 32'h1111, 32'h2222, 0, 32'h93, 32'h3333);
        mode(5'h10);
        chk_regs("R2", 32'h4444, 32'h5555, 0, 32'h90, 32'h6666);
    endtask

    task automatic t_same_bank();
        mode(5'h10);
        chk_regs("R3", 32'h4444, 32'h5555, 0, 32'h90, 32'h6666);
        mode(5'h1F);
        chk_regs("R3", 32'h4444, 32'h5555, 0, 32'h9F, 32'h6666);
        mode(5'h10);
        chk_regs("R3", 32'h4444, 32'h5555, 0, 32'h90, 32'h6666);
    endtask

    task automatic t_soft_exc();
        wr(3'd4, 32'h0000_0000);
        chk("R10", "status write keeps mode", st, 32'h10);
        wr(3'd2, 32'h1000);
        @(negedge clk); idle(); exc_vld = 1; exc_kind = 0; vec_hi = 0;
        @(negedge clk); idle();
        chk("R7", "done pulse", {31'b0, done}, 1);
        chk_regs("R4", 32'h1111, 32'h1000, 32'h08, 32'h93, 32'h10);
        @(negedge clk);
        chk("R7", "done drops", {31'b0, done}, 0);
    endtask

    task automatic t_fetch_trap();
        wr(3'd2, 32'h2000);
        exc(3'd1, 1'b1);
        chk_regs("R6", 32'h0, 32'h2000, 32'hFFFF_000C, 32'h97, 32'h93);
    endtask

    task automatic t_data_trap_same();
        wr(3'd0, 32'h7777); wr(3'd2, 32'h3000);
        exc(3'd2, 1'b0);
        chk_regs("R3", 32'h7777, 32'h3000, 32'h10, 32'h97, 32'h97);
    endtask

    task automatic t_irq_and_back();
        exc(3'd3, 1'b1);
        chk_regs("R5", 32'h0, 32'h10, 32'hFFFF_0018, 32'h92, 32'h97);
        mode(5'h17);
        chk_regs("R2", 32'h7777, 32'h3000, 32'hFFFF_0018, 32'h97, 32'h97);
        mode(5'h13);
        chk_regs("R2", 32'h1111, 32'h1000, 32'hFFFF_0018, 32'h93, 32'h10);
    endtask

    task automatic t_priority();
        @(negedge clk); idle();
        exc_vld = 1; exc_kind = 3; mode_vld = 1; mode_req = 5'h10;
        wr_en = 1; wr_sel = 0; wr_data = 32'hDEAD;
        @(negedge clk); idle();
        chk_regs("R9", 32'h0, 32'hFFFF_0018, 32'h18, 32'h92, 32'h93);
        @(negedge clk); idle();
        mode_vld = 1; mode_req = 5'h13; wr_en = 1; wr_sel = 0; wr_data = 32'hBEEF;
        @(negedge clk); idle();
        chk("R9", "write loses to mode", sp, 32'h1111);
    endtask

    task automatic t_bad_kind();
        exc(3'd5, 1'b1);
        chk("R8", "done stays low", {31'b0, done}, 0);
        chk("R8", "err set", {31'b0, err}, 1);
        chk_regs("R8", 32'h1111, 32'h1000, 32'h18, 32'h93, 32'h10);
        wr(3'd0, 32'h5A5A);
        chk("R8", "err sticky", {31'b0, err}, 1);
    endtask

    initial begin
        rst_n = 0; idle();
        t_reset();
        t_bad_mode();
        t_reset();
        t_swap();
        t_same_bank();
        t_soft_exc();
        t_fetch_trap();
        t_data_trap_same();
        t_irq_and_back();
        t_priority();
        t_bad_kind();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule